// File: doc/BRIEF.md
# Extended-Data-Out DRAM Device Model

This block is a clock-synchronous behavioural model of a by-16 dynamic memory with a multiplexed address bus. It is meant to sit on the far side of a DRAM controller in a chip-level simulation or an emulation build. The model samples the active-low row strobe, two column strobes (one per byte), write enable and output enable on every rising edge of a system clock that runs much faster than the strobes. From the edges it sees, it decodes row activation, column reads, early and late writes, page-mode column cycles, row-only refresh and refresh with the column strobe asserted first.

A row address is captured on the row strobe's falling edge and a column address on each column strobe's falling edge. The array therefore holds 2^(2*ADDR_W) words. With `ADDR_W = 8` the array is 64K x 16 with 256-word pages. The default of 5 keeps the array at 1K words so that it elaborates quickly. Read data is held after the column strobe rises and changes only on the next column falling edge. Each byte lane has its own output enable. A refresh strobe and the refreshed row are brought out so that a controller's refresh schedule can be checked. An internal counter supplies the row for refreshes in which a column strobe is low first.

Top module: `edo_dram_model`

## Requirements
- R1: After reset `dq_oe` is 00 and `rfsh_stb` is 0.
- R2: `dq_oe[1]` enables `dq_out[15:8]` and is controlled by `ucas_n`. `dq_oe[0]` enables `dq_out[7:0]` and is controlled by `lcas_n`. A lane whose column strobe stays high stays disabled, and a write to one lane leaves the other byte of the word unchanged.
- R3: A column falling edge with `ras_n` low in an opened row and `we_n` high is a read. The addressed byte appears on `dq_out` and its `dq_oe` bit is 1 while `oe_n` is low, one clock after the edge is sampled.
- R4: A column falling edge with `we_n` already low is a write of `dq_in` to the addressed byte, and the lane stays disabled. A `we_n` falling edge while the column strobe is low writes to the column latched at that strobe's edge.
- R5: In page mode (`ras_n` held low), read data and `dq_oe` hold after the column strobe rises. They change only at the next column falling edge, which reads the new column.
- R6: A row falling edge with either column strobe low is a counter refresh. It pulses `rfsh_stb` with `rfsh_row` equal to the counter, ignores `addr` and `dq_in`, and leaves the array unchanged.
- R7: A row falling edge with both column strobes high pulses `rfsh_stb` for one cycle with `rfsh_row` equal to `addr`. If no column strobe follows, the outputs stay disabled.
- R8: Hidden refresh: after a read, if the column strobe stays low while `ras_n` rises and falls again, the output stays enabled with the same data and a counter refresh is performed.
- R9: A lane is disabled when `oe_n` is high, after `we_n` is sampled low, or after `ras_n` and its column strobe are both sampled high.
- R10: The refresh counter is ADDR_W bits wide, resets to 0, increments after each counter refresh and wraps from all-ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Per-byte output enable, [1] upper, [0] lower |
| rfsh_stb | output | 1 | One-cycle pulse on every row activation or refresh |
| rfsh_row | output | ADDR_W | Row refreshed with that pulse |

## Verification
Reads are run on words written through both strobes, then on words where one lane was overwritten, so that a lane that ignores its own strobe shows up. Early writes and late writes, where write enable falls after a read has started, are both read back. This separates the column used by the late write and shows the output being released. Page-mode sequences read one column, raise the strobe and read another, so that the hold after the rising edge can be told apart from a fresh read. Row-only refresh, counter refresh with junk address and data, a full wrap of the counter and a hidden refresh after a read separate the two row sources and check that the output survives the row strobe cycling.

// File: rtl/edo_pkg.sv
// Shared constants for the EDO DRAM model.
// Assumes strobes are already synchronous to clk.
package edo_pkg;
    // Bit positions inside the packed strobe vector
    localparam int STB_W   = 4;
    localparam int STB_RAS = 3;
    localparam int STB_WE  = 2;
    localparam int STB_UC  = 1;   // upper column strobe, lane 1
    localparam int STB_LC  = 0;   // lower column strobe, lane 0
    localparam int LANES   = 2;
    localparam int LANE_W  = 8;
endpackage

// File: rtl/edo_edge_det.sv
// Registers the active-low strobes and reports their falling and rising edges.
// Assumes: inputs are synchronous; reset value is the idle (all high) level.
module edo_edge_det
    import edo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STB_W-1:0] stb_n,
    output logic [STB_W-1:0] fall,
    output logic [STB_W-1:0] rise
);
    logic [STB_W-1:0] stb_q;

    // Hold last sampled strobe levels
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= '1;
        else        stb_q <= stb_n;
    end

    // Edge decode against the previous sample
    always_comb begin
        fall = stb_q & ~stb_n;
        rise = ~stb_q & stb_n;
    end
endmodule

// File: rtl/edo_row_ctrl.sv
// Row activation and refresh control: latches the row, runs the refresh
// counter and emits a refresh pulse on every row strobe falling edge.
// Assumes: column strobe levels are sampled in the same cycle as ras_fall.
module edo_row_ctrl #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic [1:0]        cas_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] row_q,
    output logic              row_open,
    output logic              rfsh_stb,
    output logic [ADDR_W-1:0] rfsh_row
);
    logic [ADDR_W-1:0] cnt_q;
    logic              cas_first;

    // Any column strobe low at row fall selects counter refresh
    always_comb cas_first = ~(&cas_n);

    // Row latch, refresh counter and refresh pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            row_open <= 1'b0;
            rfsh_stb <= 1'b0;
            rfsh_row <= '0;
            cnt_q    <= '0;
        end else begin
            rfsh_stb <= 1'b0;
            if (ras_fall) begin
                rfsh_stb <= 1'b1;
                if (cas_first) begin
                    rfsh_row <= cnt_q;
                    cnt_q    <= cnt_q + 1'b1;
                    row_open <= 1'b0;
                end else begin
                    rfsh_row <= addr;
                    row_q    <= addr;
                    row_open <= 1'b1;
                end
            end else if (ras_rise) begin
                row_open <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/edo_byte_lane.sv
// One byte lane: storage array, column latch, EDO output latch and drive flag.
// Assumes: access_ok is high only while a row opened by a normal activation
// is held by a low row strobe.
module edo_byte_lane #(
    parameter int ADDR_W = 5,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cas_fall,
    input  logic              cas_n,
    input  logic              we_fall,
    input  logic              we_n,
    input  logic              ras_n,
    input  logic              access_ok,
    input  logic [ADDR_W-1:0] row,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout,
    output logic              drv
);
    localparam int IDX_W = 2 * ADDR_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [LANE_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] col_q;
    logic              wr_now;
    logic              rd_now;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    // Decode write (early or late) and read for this lane
    always_comb begin
        wr_now = access_ok & ~cas_n & ~we_n & (cas_fall | we_fall);
        rd_now = access_ok & cas_fall & we_n;
        wr_idx = cas_fall ? {row, addr} : {row, col_q};
        rd_idx = {row, addr};
    end

    // Array write and EDO read latch (no reset on storage)
    always_ff @(posedge clk) begin
        if (wr_now) mem[wr_idx] <= din;
        if (rd_now) dout <= mem[rd_idx];
    end

    // Column latch and output drive flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            drv   <= 1'b0;
        end else if (cas_fall) begin
            if (access_ok) col_q <= addr;
            drv <= rd_now;
        end else if (!we_n) begin
            drv <= 1'b0;
        end else if (ras_n && cas_n) begin
            drv <= 1'b0;
        end
    end
endmodule

// File: rtl/edo_dram_model.sv
// Top of the EDO DRAM model: edge detection, row/refresh control and two
// byte lanes generated from the lane count.
// Assumes: clk is much faster than the strobes; inputs change away from clk.
module edo_dram_model #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              ucas_n,
    input  logic              lcas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe,
    output logic              rfsh_stb,
    output logic [ADDR_W-1:0] rfsh_row
);
    import edo_pkg::*;

    logic [STB_W-1:0]  stb_n;
    logic [STB_W-1:0]  fall;
    logic [STB_W-1:0]  rise;
    logic [ADDR_W-1:0] row_q;
    logic              row_open;
    logic              access_ok;
    logic [1:0]        cas_n;
    logic [LANES-1:0]  drv;

    // Pack strobes; lane index equals column-strobe bit
    always_comb begin
        stb_n = '0;
        stb_n[STB_RAS] = ras_n;
        stb_n[STB_WE]  = we_n;
        stb_n[STB_UC]  = ucas_n;
        stb_n[STB_LC]  = lcas_n;
        cas_n          = {ucas_n, lcas_n};
        access_ok      = row_open & ~ras_n;
    end

    edo_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_n (stb_n),
        .fall  (fall),
        .rise  (rise)
    );

    edo_row_ctrl #(.ADDR_W(ADDR_W)) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_fall (fall[STB_RAS]),
        .ras_rise (rise[STB_RAS]),
        .cas_n    (cas_n),
        .addr     (addr),
        .row_q    (row_q),
        .row_open (row_open),
        .rfsh_stb (rfsh_stb),
        .rfsh_row (rfsh_row)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        edo_byte_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .cas_fall  (fall[STB_LC + l]),
            .cas_n     (cas_n[l]),
            .we_fall   (fall[STB_WE]),
            .we_n      (we_n),
            .ras_n     (ras_n),
            .access_ok (access_ok),
            .row       (row_q),
            .addr      (addr),
            .din       (dq_in[l*LANE_W +: LANE_W]),
            .dout      (dq_out[l*LANE_W +: LANE_W]),
            .drv       (drv[l])
        );
        // Output enable gated live by oe_n
        assign dq_oe[l] = drv[l] & ~oe_n;
    end
endmodule

// File: rtl/edo_dram_chk.sv
// Protocol checker for edo_dram_model, attached with bind.
// Assumes: the same clock and synchronous reset as the model.
module edo_dram_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              ucas_n,
    input logic              lcas_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [15:0]       dq_out,
    input logic [1:0]        dq_oe,
    input logic              rfsh_stb,
    input logic [ADDR_W-1:0] rfsh_row
);
    logic              ucas_q, lcas_q;
    logic              cbr_seen;
    logic              have_prev;
    logic [ADDR_W-1:0] prev_row;

    // Column strobe levels from the previous sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ucas_q <= 1'b1;
            lcas_q <= 1'b1;
        end else begin
            ucas_q <= ucas_n;
            lcas_q <= lcas_n;
        end
    end

    always_comb cbr_seen = rfsh_stb & ~(ucas_q & lcas_q);

    // Remember the row of the last counter refresh
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_row  <= '0;
        end else if (cbr_seen) begin
            have_prev <= 1'b1;
            prev_row  <= rfsh_row;
        end
    end

    // R10
    cbr_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cbr_seen && have_prev) |-> rfsh_row == ADDR_W'(prev_row + 1'b1));

    // R7
    rfsh_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_stb |=> !rfsh_stb);

    // R9
    we_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> dq_oe == 2'b00);

    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && ucas_n && lcas_n) |=> dq_oe == 2'b00);

    // R2
    upper_lane_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe[1] |-> !($past(ras_n) && $past(ucas_n)));

    // R5
    edo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && lcas_n && !lcas_q && dq_oe[0] && we_n) |=> $stable(dq_out[7:0]));
endmodule

bind edo_dram_model edo_dram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .ucas_n   (ucas_n),
    .lcas_n   (lcas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .rfsh_stb (rfsh_stb),
    .rfsh_row (rfsh_row)
);

// File: tb/tb_edo_dram_model.sv
// Directed bench for edo_dram_model: one task per scenario.
module tb_edo_dram_model;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic [1:0]    dq_oe;
    logic          rfsh_stb;
    logic [AW-1:0] rfsh_row;

    int            checks = 0;
    int            errors = 0;
    logic [AW-1:0] exp_cnt = '0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    edo_dram_model #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply strobes at a falling clock edge, wait one full clock
    task automatic step(input logic r, input logic u, input logic l, input logic w,
                        input logic o, input logic [AW-1:0] a, input logic [15:0] d);
        ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o; addr = a; dq_in = d;
        @(negedge clk);
    endtask

    task automatic idle();
        step(1, 1, 1, 1, 0, '0, '0);
    endtask

    task automatic write_word(input logic [AW-1:0] row, input logic [AW-1:0] col,
                              input logic [15:0] d, input logic [1:0] lanes);
        idle();
        step(0, 1, 1, 1, 0, row, '0);
        step(0, ~lanes[1], ~lanes[0], 0, 0, col, d);
        chk(dq_oe == 2'b00, "R4 early write keeps lanes off", {14'b0, dq_oe}, 16'h0);
        idle();
    endtask

    task automatic read_word(input logic [AW-1:0] row, input logic [AW-1:0] col,
                             input logic [15:0] exp, input string tag);
        idle();
        step(0, 1, 1, 1, 0, row, '0);
        step(0, 0, 0, 1, 0, col, '0);
        chk(dq_oe == 2'b11, {tag, " drive"}, {14'b0, dq_oe}, 16'h3);
        chk(dq_out == exp, {tag, " data"}, dq_out, exp);
        idle();
    endtask

    task automatic t_reset();
        chk(dq_oe == 2'b00, "R1 dq_oe", {14'b0, dq_oe}, 16'h0);
        chk(rfsh_stb == 1'b0, "R1 rfsh_stb", {15'b0, rfsh_stb}, 16'h0);
    endtask

    task automatic t_word_rw();
        write_word(5'd3, 5'd7, 16'hA5C3, 2'b11);
        read_word(5'd3, 5'd7, 16'hA5C3, "R3 word read");
        write_word(5'd31, 5'd0, 16'h1234, 2'b11);
        read_word(5'd31, 5'd0, 16'h1234, "R3 corner address");
        read_word(5'd3, 5'd7, 16'hA5C3, "R3 no alias");
    endtask

    task automatic t_byte_lanes();
        write_word(5'd3, 5'd7, 16'h77EE, 2'b10);
        read_word(5'd3, 5'd7, 16'h77C3, "R2 upper write only");
        write_word(5'd3, 5'd7, 16'hFF11, 2'b01);
        read_word(5'd3, 5'd7, 16'h7711, "R2 lower write only");
        idle();
        step(0, 1, 1, 1, 0, 5'd3, '0);
        step(0, 0, 1, 1, 0, 5'd7, '0);
        chk(dq_oe == 2'b10, "R2 upper-only read lane enables", {14'b0, dq_oe}, 16'h2);
        chk(dq_out[15:8] == 8'h77, "R2 upper-only data", {8'b0, dq_out[15:8]}, 16'h77);
        idle();
    endtask

    task automatic t_late_write();
        write_word(5'd9, 5'd2, 16'h0F0F, 2'b11);
        idle();
        step(0, 1, 1, 1, 0, 5'd9, '0);
        step(0, 0, 0, 1, 0, 5'd2, '0);
        chk(dq_out == 16'h0F0F, "R3 read before late write", dq_out, 16'h0F0F);
        step(0, 0, 0, 0, 0, 5'd20, 16'hBEEF);
        chk(dq_oe == 2'b00, "R9 we low releases", {14'b0, dq_oe}, 16'h0);
        idle();
        read_word(5'd9, 5'd2, 16'hBEEF, "R4 late write latched column");
        read_word(5'd9, 5'd20, 16'h0000 | 16'hxxxx, "R4 other column") ;
    endtask

    task automatic t_page_oe();
        write_word(5'd4, 5'd1, 16'h1111, 2'b11);
        write_word(5'd4, 5'd2, 16'h2222, 2'b11);
        idle();
        step(0, 1, 1, 1, 0, 5'd4, '0);
        step(0, 0, 0, 1, 0, 5'd1, '0);
        chk(dq_out == 16'h1111, "R5 first column", dq_out, 16'h1111);
        step(0, 1, 1, 1, 0, 5'd2, '0);
        step(0, 1, 1, 1, 0, 5'd2, '0);
        chk(dq_oe == 2'b11, "R5 drive held after strobe rise", {14'b0, dq_oe}, 16'h3);
        chk(dq_out == 16'h1111, "R5 data held after strobe rise", dq_out, 16'h1111);
        step(0, 0, 0, 1, 0, 5'd2, '0);
        chk(dq_out == 16'h2222, "R5 next column", dq_out, 16'h2222);
        step(0, 0, 0, 1, 1, 5'd2, '0);
        chk(dq_oe == 2'b00, "R9 oe high releases", {14'b0, dq_oe}, 16'h0);
        step(0, 0, 0, 1, 0, 5'd2, '0);
        chk(dq_oe == 2'b11, "R9 oe low drives again", {14'b0, dq_oe}, 16'h3);
        step(1, 1, 1, 1, 0, 5'd2, '0);
        chk(dq_oe == 2'b00, "R9 row and column high release", {14'b0, dq_oe}, 16'h0);
    endtask

    task automatic t_ras_only();
        idle();
        step(0, 1, 1, 1, 0, 5'd22, '0);
        chk(rfsh_stb == 1'b1, "R7 pulse", {15'b0, rfsh_stb}, 16'h1);
        chk(rfsh_row == 5'd22, "R7 row from addr", {11'b0, rfsh_row}, 16'd22);
        step(0, 1, 1, 1, 0, 5'd22, '0);
        chk(rfsh_stb == 1'b0, "R7 single pulse", {15'b0, rfsh_stb}, 16'h0);
        chk(dq_oe == 2'b00, "R7 outputs off", {14'b0, dq_oe}, 16'h0);
        idle();
    endtask

    task automatic cbr_once(input bit check_row);
        idle();
        step(1, 0, 0, 0, 0, 5'd3, 16'hDEAD);
        step(0, 0, 0, 0, 0, 5'd7, 16'hDEAD);
        if (check_row) begin
            chk(rfsh_stb == 1'b1, "R6 pulse", {15'b0, rfsh_stb}, 16'h1);
            chk(rfsh_row == exp_cnt, "R6 row from counter", {11'b0, rfsh_row}, {11'b0, exp_cnt});
            chk(dq_oe == 2'b00, "R6 outputs off", {14'b0, dq_oe}, 16'h0);
        end
        exp_cnt = exp_cnt + 1'b1;
        idle();
    endtask

    task automatic t_cbr();
        cbr_once(1'b1);
        cbr_once(1'b1);
        read_word(5'd3, 5'd7, 16'h7711, "R6 array untouched");
        for (int i = 0; i < (1 << AW); i++) cbr_once(1'b0);
        cbr_once(1'b1);   // R10 wrapped counter matches modulo count
    endtask

    task automatic t_hidden();
        idle();
        step(0, 1, 1, 1, 0, 5'd3, '0);
        step(0, 0, 0, 1, 0, 5'd7, '0);
        step(1, 0, 0, 1, 0, 5'd7, '0);
        chk(dq_oe == 2'b11, "R8 drive through row rise", {14'b0, dq_oe}, 16'h3);
        step(0, 0, 0, 1, 0, 5'd9, '0);
        chk(rfsh_stb == 1'b1 && rfsh_row == exp_cnt, "R8 hidden refresh row", {11'b0, rfsh_row}, {11'b0, exp_cnt});
        exp_cnt = exp_cnt + 1'b1;
        chk(dq_oe == 2'b11, "R8 drive kept", {14'b0, dq_oe}, 16'h3);
        chk(dq_out == 16'h7711, "R8 data kept", dq_out, 16'h7711);
        idle();
        idle();
        chk(dq_oe == 2'b00, "R9 released after hidden refresh", {14'b0, dq_oe}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_rw();
        t_byte_lanes();
        t_page_oe();
        t_ras_only();
        t_cbr();
        t_hidden();
        t_late_write();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule